// File: doc/BRIEF.md
# Accumulator Datapath Unit with Status Flags

This unit does the arithmetic and logic work of an 8-bit accumulator processor. Each accepted request names one operation and supplies the accumulator, the second (B) register, a general operand and the current carry, auxiliary-carry and overflow flags. One clock later it returns the new accumulator, the new B register, the operand as it should be written back, and the updated flags. Register file access, address generation and sequencing belong to the surrounding core.

The flag rules follow the machine's conventions. Addition and subtraction update all three flags, and subtraction always takes the incoming carry as a borrow. Increment and decrement leave every flag as it was. The bitwise, clear, complement, rotate, swap and digit-exchange operations also leave the flags alone, with one exception: the rotates through carry write C. Multiply and divide clear C and use OV as their status bit. Decimal adjust can only set C, never clear it.

Top module: `acc_alu`

## Requirements
- R1: Whenever `op_valid` is sampled high, `res_valid` is high in the next cycle and the outputs hold that operation's results. When `op_valid` is low, `res_valid` drops and the data outputs keep their values. A synchronous reset clears every output to zero.
- R2: ADD (code 0) and ADDC (code 1) compute A + operand, where ADDC also adds the carry in. C is set when the unsigned sum is above FFh. AC is set on a carry out of bit 3. OV is the XOR of the carries out of bits 6 and 7. For example, 3Fh + D3h gives 12h with C=1, AC=1 and OV=0.
- R3: SUBB (code 2) computes A − operand − C. C reports a borrow out of bit 7, AC reports a borrow out of bit 3, and OV is set when the signed result lies outside −128..127.
- R4: INC (code 3) and DEC (code 4) add or subtract one from A, wrapping modulo 256. All three flags keep their input values.
- R5: The following operations leave all three flags at their input values: AND (code 8), OR (code 9), XOR (code 10) with the operand, CPL (code 11, invert A), CLR (code 12, A becomes 0), RL (code 13, rotate left), RR (code 15, rotate right) and SWAP.
- R6: MUL (code 5) puts the 16-bit product A×B in {B, A}, with B holding the high byte. It clears C and sets OV exactly when the high byte is nonzero. For example, FFh×FFh gives B=FEh and A=01h.
- R7: DIV (code 6) with a nonzero B puts the quotient A/B in A and the remainder in B. It clears C and OV.
- R8: DIV with B equal to zero sets OV and clears C. The A and B results are not defined in this case.
- R9: DA (code 7) adds 06h when the low nibble of A is above 9 or AC is set. It then adds 60h when the high nibble is above 9, C is set, or the first step carried. C becomes set if any carry occurred and is otherwise left unchanged. For example, 4Ch with no flags set gives 52h.
- R10: RLC (code 14) and RRC (code 16) rotate through C as a ninth bit. For example, BDh rotated right with C=0 gives 5Eh with C=1. AC and OV are unchanged.
- R11: SWAP (code 17) exchanges the nibbles of A, so 72h becomes 27h. XCHD (code 18) exchanges only the low nibbles of A and the operand, and `opnd_out` returns the new operand. For every other operation, `opnd_out` equals the operand input.
- R12: Codes 19 to 31 leave A, B and all flags unchanged. For every operation except MUL and DIV, `breg_out` equals `breg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator value |
| breg_in | input | 8 | B register value |
| opnd_in | input | 8 | General operand |
| cy_in | input | 1 | Carry flag in |
| ac_in | input | 1 | Auxiliary-carry flag in |
| ov_in | input | 1 | Overflow flag in |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| acc_out | output | 8 | New accumulator |
| breg_out | output | 8 | New B register |
| opnd_out | output | 8 | Operand to write back |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The unit holds no state across operations except its output register, so any internal fault appears on the ports one cycle after the request that exposes it. A mis-selected result path shows up as a wrong accumulator or B value. Broken carry chains show up as wrong C, AC or OV values on boundary operands such as 7Fh+01h, 80h−01h, nibble overflows and a zero divisor. A flag path that leaks into an operation meant to preserve flags is caught by driving incoming flags that differ from what an arithmetic result would produce.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int WORD   = 8;
    localparam int OPBITS = 5;

    typedef enum logic [OPBITS-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
        OP_DEC  = 5'd4,  OP_MUL  = 5'd5,  OP_DIV  = 5'd6,  OP_DA   = 5'd7,
        OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CPL  = 5'd11,
        OP_CLR  = 5'd12, OP_RL   = 5'd13, OP_RLC  = 5'd14, OP_RR   = 5'd15,
        OP_RRC  = 5'd16, OP_SWAP = 5'd17, OP_XCHD = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } psw_t;

    typedef struct packed {
        logic [WORD-1:0] acc;
        logic [WORD-1:0] breg;
        logic [WORD-1:0] opnd;
        psw_t            psw;
    } alu_res_t;

    function automatic logic keeps_all_flags(input logic [OPBITS-1:0] op);
        case (op)
            OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CPL,
            OP_CLR, OP_RL, OP_RR, OP_SWAP, OP_XCHD: return 1'b1;
            default: return op > OP_XCHD;
        endcase
    endfunction

    function automatic logic uses_adder(input logic [OPBITS-1:0] op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = acc_alu_pkg::WORD
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cy,
    output logic          ac,
    output logic          ov
);
    localparam int NIB = DW / 2;

    logic [DW-1:0] b_eff;
    logic          ci;
    logic [DW:0]   full;
    logic [NIB:0]  low;
    logic [DW-1:0] below;

    always_comb begin
        b_eff = sub ? ~b : b;
        ci    = cin ^ sub;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, ci};
        low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, ci};
        below = {1'b0, a[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, ci};
        sum   = full[DW-1:0];
        cy    = full[DW] ^ sub;
        ac    = low[NIB] ^ sub;
        ov    = below[DW-1] ^ full[DW];
    end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
    parameter int DW = acc_alu_pkg::WORD
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] prod_hi,
    output logic [DW-1:0] prod_lo,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem,
    output logic          div_zero
);
    logic [2*DW-1:0] prod;
    logic [DW:0]     trial;
    logic [DW-1:0]   part;

    assign prod     = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    assign prod_hi  = prod[2*DW-1:DW];
    assign prod_lo  = prod[DW-1:0];
    assign div_zero = (b == '0);

    // restoring division, one quotient bit per unrolled step
    always_comb begin
        part  = '0;
        quo   = '0;
        trial = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            trial = {part, a[i]};
            if (trial >= {1'b0, b}) begin
                trial  = trial - {1'b0, b};
                quo[i] = 1'b1;
            end
            part = trial[DW-1:0];
        end
        rem = part;
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
    parameter int DW = acc_alu_pkg::WORD
) (
    input  logic [DW-1:0] a,
    input  logic          cy,
    input  logic          ac,
    output logic [DW-1:0] res,
    output logic          cy_o
);
    localparam int NIB = DW / 2;
    localparam logic [DW:0] FIX_LO = (DW+1)'(6);
    localparam logic [DW:0] FIX_HI = (DW+1)'(6) << NIB;
    localparam logic [NIB-1:0] DIGMAX = NIB'(9);

    logic          lo_fix, hi_fix;
    logic [DW:0]   step1, step2;

    always_comb begin
        lo_fix = (a[NIB-1:0] > DIGMAX) || ac;
        step1  = {1'b0, a} + (lo_fix ? FIX_LO : '0);
        hi_fix = step1[DW] || cy || (step1[DW-1:NIB] > DIGMAX);
        step2  = step1 + (hi_fix ? FIX_HI : '0);
        res    = step2[DW-1:0];
        cy_o   = cy | step1[DW] | step2[DW];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
    parameter int DW = acc_alu_pkg::WORD
) (
    input  logic [acc_alu_pkg::OPBITS-1:0] op,
    input  logic [DW-1:0]                  a,
    input  logic [DW-1:0]                  opnd,
    input  logic                           cy,
    output logic [DW-1:0]                  res,
    output logic [DW-1:0]                  opnd_res,
    output logic                           cy_o
);
    import acc_alu_pkg::*;
    localparam int NIB = DW / 2;

    always_comb begin
        res      = a;
        opnd_res = opnd;
        cy_o     = cy;
        case (op)
            OP_INC:  res = a + DW'(1);
            OP_DEC:  res = a - DW'(1);
            OP_AND:  res = a & opnd;
            OP_OR:   res = a | opnd;
            OP_XOR:  res = a ^ opnd;
            OP_CPL:  res = ~a;
            OP_CLR:  res = '0;
            OP_RL:   res = {a[DW-2:0], a[DW-1]};
            OP_RR:   res = {a[0], a[DW-1:1]};
            OP_RLC: begin
                res  = {a[DW-2:0], cy};
                cy_o = a[DW-1];
            end
            OP_RRC: begin
                res  = {cy, a[DW-1:1]};
                cy_o = a[0];
            end
            OP_SWAP: res = {a[NIB-1:0], a[DW-1:NIB]};
            OP_XCHD: begin
                res      = {a[DW-1:NIB], opnd[NIB-1:0]};
                opnd_res = {opnd[DW-1:NIB], a[NIB-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OPBITS-1:0] op_sel,
    input  logic [WORD-1:0]   acc_in,
    input  logic [WORD-1:0]   breg_in,
    input  logic [WORD-1:0]   opnd_in,
    input  logic              cy_in,
    input  logic              ac_in,
    input  logic              ov_in,
    output logic              res_valid,
    output logic [WORD-1:0]   acc_out,
    output logic [WORD-1:0]   breg_out,
    output logic [WORD-1:0]   opnd_out,
    output logic              cy_out,
    output logic              ac_out,
    output logic              ov_out
);
    logic [WORD-1:0] as_sum;
    logic            as_cy, as_ac, as_ov, as_cin, as_sub;
    logic [WORD-1:0] md_hi, md_lo, md_quo, md_rem;
    logic            md_dz;
    logic [WORD-1:0] da_res;
    logic            da_cy;
    logic [WORD-1:0] bo_res, bo_opnd;
    logic            bo_cy;
    alu_res_t        nxt, cur;

    assign as_sub = (op_sel == OP_SUBB);
    assign as_cin = (op_sel == OP_ADD) ? 1'b0 : cy_in;

    alu_addsub #(.DW(WORD)) u_addsub (
        .a(acc_in), .b(opnd_in), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cy(as_cy), .ac(as_ac), .ov(as_ov)
    );

    alu_muldiv #(.DW(WORD)) u_muldiv (
        .a(acc_in), .b(breg_in), .prod_hi(md_hi), .prod_lo(md_lo),
        .quo(md_quo), .rem(md_rem), .div_zero(md_dz)
    );

    alu_decadj #(.DW(WORD)) u_decadj (
        .a(acc_in), .cy(cy_in), .ac(ac_in), .res(da_res), .cy_o(da_cy)
    );

    alu_bitops #(.DW(WORD)) u_bitops (
        .op(op_sel), .a(acc_in), .opnd(opnd_in), .cy(cy_in),
        .res(bo_res), .opnd_res(bo_opnd), .cy_o(bo_cy)
    );

    always_comb begin
        nxt.acc    = bo_res;
        nxt.breg   = breg_in;
        nxt.opnd   = bo_opnd;
        nxt.psw.cy = bo_cy;
        nxt.psw.ac = ac_in;
        nxt.psw.ov = ov_in;
        if (uses_adder(op_sel)) begin
            nxt.acc = as_sum;
            nxt.psw = '{cy: as_cy, ac: as_ac, ov: as_ov};
        end else if (op_sel == OP_MUL) begin
            nxt.acc    = md_lo;
            nxt.breg   = md_hi;
            nxt.psw.cy = 1'b0;
            nxt.psw.ov = (md_hi != '0);
        end else if (op_sel == OP_DIV) begin
            if (!md_dz) begin
                nxt.acc  = md_quo;
                nxt.breg = md_rem;
            end
            nxt.psw.cy = 1'b0;
            nxt.psw.ov = md_dz;
        end else if (op_sel == OP_DA) begin
            nxt.acc    = da_res;
            nxt.psw.cy = da_cy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            cur       <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) cur <= nxt;
        end
    end

    assign acc_out  = cur.acc;
    assign breg_out = cur.breg;
    assign opnd_out = cur.opnd;
    assign cy_out   = cur.psw.cy;
    assign ac_out   = cur.psw.ac;
    assign ov_out   = cur.psw.ov;

    // R1: a request produces a result strobe one cycle later
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R4, R5: flag-preserving operations return the incoming flags
    a_r5_flags_kept: assert property (@(posedge clk) disable iff (rst)
        (op_valid && keeps_all_flags(op_sel)) |=>
        (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in)));

    // R6: multiply result pair equals the product of the inputs
    a_r6_mul_product: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_MUL) |=>
        ({breg_out, acc_out} == ({8'd0, $past(acc_in)} * {8'd0, $past(breg_in)})));

    // R7, R8: divide always clears carry
    a_r7_div_clears_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_DIV) |=> !cy_out);

    // R8: zero divisor flagged through OV
    a_r8_div_zero_ov: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_DIV && breg_in == '0) |=> ov_out);

    // R9: decimal adjust never clears an incoming carry
    a_r9_da_carry_sticky: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_DA && cy_in) |=> cy_out);

    // R12: B passes through for everything but multiply and divide
    a_r12_breg_pass: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel != OP_MUL && op_sel != OP_DIV) |=> (breg_out == $past(breg_in)));
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    import acc_alu_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] acc_in = '0, breg_in = '0, opnd_in = '0;
    logic cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic res_valid;
    logic [7:0] acc_out, breg_out, opnd_out;
    logic cy_out, ac_out, ov_out;

    always #2.5 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .breg_in(breg_in), .opnd_in(opnd_in),
        .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .res_valid(res_valid), .acc_out(acc_out), .breg_out(breg_out),
        .opnd_out(opnd_out), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
    );

    typedef struct {
        string      req;
        logic       data_ok;
        logic [7:0] a, b, o;
        logic       c, h, v;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic fail_line(input string req, input string what, input int act, input int expv);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    endtask

    // independent reference model built from the requirements
    function automatic exp_t model(input int op, input int a, input int b, input int o,
                                   input int c, input int h, input int v, input string req);
        exp_t e;
        int r, t, sa, so, cin;
        e.req = req; e.data_ok = 1; e.b = 8'(b); e.o = 8'(o);
        e.a = 8'(a); e.c = c[0]; e.h = h[0]; e.v = v[0];
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                r = a + o + cin;
                sa = (a > 127) ? a - 256 : a; so = (o > 127) ? o - 256 : o;
                e.a = 8'(r); e.c = r > 255; e.h = ((a & 15) + (o & 15) + cin) > 15;
                e.v = (sa + so + cin > 127) || (sa + so + cin < -128);
            end
            2: begin
                r = a - o - c;
                sa = (a > 127) ? a - 256 : a; so = (o > 127) ? o - 256 : o;
                e.a = 8'(r); e.c = r < 0; e.h = ((a & 15) - (o & 15) - c) < 0;
                e.v = (sa - so - c > 127) || (sa - so - c < -128);
            end
            3: e.a = 8'(a + 1);
            4: e.a = 8'(a + 255);
            5: begin r = a * b; e.a = 8'(r); e.b = 8'(r >> 8); e.c = 0; e.v = (r > 255); end
            6: begin
                e.c = 0;
                if (b == 0) begin e.v = 1; e.data_ok = 0; end
                else begin e.a = 8'(a / b); e.b = 8'(a % b); e.v = 0; end
            end
            7: begin
                t = a;
                if ((t & 15) > 9 || h) t = t + 6;
                if (((t >> 4) & 15) > 9 || c || t > 255) t = t + 96;
                e.c = c || (t > 255); e.a = 8'(t);
            end
            8:  e.a = 8'(a & o);
            9:  e.a = 8'(a | o);
            10: e.a = 8'(a ^ o);
            11: e.a = 8'(255 - a);
            12: e.a = 8'h00;
            13: e.a = 8'(((a << 1) & 254) | (a >> 7));
            14: begin e.a = 8'(((a << 1) & 254) | c); e.c = a[7]; end
            15: e.a = 8'((a >> 1) | ((a & 1) << 7));
            16: begin e.a = 8'((a >> 1) | (c << 7)); e.c = a[0]; end
            17: e.a = 8'(((a & 15) << 4) | (a >> 4));
            18: begin e.a = 8'((a & 240) | (o & 15)); e.o = 8'((o & 240) | (a & 15)); end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int b, input int o,
                         input int c, input int h, input int v, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_sel = 5'(op);
        acc_in = 8'(a); breg_in = 8'(b); opnd_in = 8'(o);
        cy_in = c[0]; ac_in = h[0]; ov_in = v[0];
        exp_q.push_back(model(op, a, b, o, c, h, v, req));
    endtask

    // monitor: compare each result as it appears
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (!rst && res_valid) begin
                checks++;
                if (exp_q.size() == 0) fail_line("R1", "unexpected_valid", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    if (e.data_ok && acc_out  !== e.a) fail_line(e.req, "acc",  acc_out, e.a);
                    if (e.data_ok && breg_out !== e.b) fail_line(e.req, "breg", breg_out, e.b);
                    if (opnd_out !== e.o) fail_line(e.req, "opnd", opnd_out, e.o);
                    if (cy_out !== e.c) fail_line(e.req, "cy", cy_out, e.c);
                    if (ac_out !== e.h) fail_line(e.req, "ac", ac_out, e.h);
                    if (ov_out !== e.v) fail_line(e.req, "ov", ov_out, e.v);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        checks++; // R1 reset state
        if ({res_valid, acc_out, breg_out, opnd_out, cy_out, ac_out, ov_out} !== '0)
            fail_line("R1", "reset", int'(acc_out), 0);

        drive(0, 8'h3F, 8'h11, 8'hD3, 0, 0, 1, "R2");  // 12h C1 AC1 OV0
        drive(0, 8'h7F, 8'h00, 8'h01, 1, 0, 0, "R2");  // signed overflow
        drive(1, 8'h80, 8'h00, 8'h7F, 1, 0, 0, "R2");  // carry in ripples
        drive(2, 8'h80, 8'h05, 8'h01, 0, 1, 0, "R3");  // signed overflow
        drive(2, 8'h10, 8'h05, 8'h4F, 1, 0, 1, "R3");  // borrow and nibble borrow
        drive(2, 8'h55, 8'h05, 8'h54, 1, 1, 1, "R3");  // exact zero via borrow
        drive(3, 8'hFF, 8'h00, 8'h00, 0, 1, 1, "R4");
        drive(4, 8'h00, 8'h00, 8'h00, 1, 0, 1, "R4");
        drive(8, 8'hAC, 8'h00, 8'h0F, 1, 1, 1, "R5");
        drive(9, 8'hAC, 8'h00, 8'h0F, 0, 1, 0, "R5");
        drive(10, 8'hAC, 8'h00, 8'h0F, 1, 0, 1, "R5");
        drive(11, 8'hAC, 8'h00, 8'h00, 1, 1, 0, "R5");
        drive(12, 8'hAC, 8'h00, 8'h00, 0, 0, 1, "R5");
        drive(13, 8'hF0, 8'h00, 8'h00, 0, 1, 1, "R5");
        drive(15, 8'h01, 8'h00, 8'h00, 1, 0, 0, "R5");
        drive(5, 8'hFF, 8'hFF, 8'h00, 1, 0, 0, "R6");
        drive(5, 8'h0C, 8'h0A, 8'h00, 1, 1, 1, "R6");
        drive(6, 8'hFB, 8'h07, 8'h00, 1, 1, 1, "R7");
        drive(6, 8'h03, 8'h09, 8'h00, 0, 0, 1, "R7");
        drive(6, 8'h42, 8'h00, 8'h00, 1, 0, 0, "R8");
        drive(7, 8'h4C, 8'h00, 8'h00, 0, 0, 0, "R9");
        drive(7, 8'h9A, 8'h00, 8'h00, 0, 0, 0, "R9");
        drive(7, 8'h12, 8'h00, 8'h00, 1, 1, 0, "R9");
        drive(14, 8'h81, 8'h00, 8'h00, 0, 1, 0, "R10");
        drive(16, 8'hBD, 8'h00, 8'h00, 0, 0, 1, "R10");
        drive(17, 8'h72, 8'h00, 8'h00, 1, 1, 1, "R11");
        drive(18, 8'h5A, 8'h00, 8'h3C, 0, 1, 0, "R11");
        drive(20, 8'h33, 8'h44, 8'h55, 1, 0, 1, "R12");
        drive(31, 8'hC3, 8'h99, 8'h00, 0, 1, 0, "R12");
        @(negedge clk);
        op_valid = 1'b0; op_sel = 5'd0; acc_in = 8'hEE;
        repeat (3) @(negedge clk);
        #2;
        checks++; // R1: idle keeps outputs
        if (res_valid !== 1'b0 || acc_out !== 8'hC3)
            fail_line("R1", "idle_hold", int'(acc_out), 8'hC3);
        checks++;
        if (exp_q.size() != 0) fail_line("R1", "missing_results", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fail_line("R1", "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule